// File: doc/BRIEF.md
# Dual-Pipe Interlock Stall Controller

This block is the flow-control logic of a small in-order machine. A single issue stage holds one instruction slot for each of two pipes and feeds them in lock step. The long pipe has two execute stages and a writeback stage after the issue stage. The short pipe has a single combined execute/writeback stage. The last stage of each pipe drives one shared completion bus, and the short pipe has priority on that bus. For every stage the block computes two flags. A moving-or-empty flag goes back to the predecessor and says whether the stage can accept new contents on the next edge. A require-to-move flag goes forward to the successor and says that the stage holds an entry that must advance.

The block also keeps a per-register scoreboard of results the long pipe still owes. It blocks issue when an operand register is outstanding, unless the completion bus is writing that register in the same cycle. Every moving-or-empty flag is the exact complement of its stall condition, so a stage holds exactly when a hazard forces it and never otherwise. Stage occupancy and destination addresses live in the block. Instruction decode, the datapath and the register file sit outside it.

Top module: `twin_pipe_interlock`

## Requirements
- R1: After reset every stage is empty, all scoreboard bits are clear, every moving-or-empty flag is set and `feed_ready` is 1.
- R2: The last stage of each pipe requests the completion bus whenever it holds an entry. A short request always wins. The long stage is granted only when the short stage does not request. `cbus_addr` carries the winner's destination, `cbus_long` is 1 when the long pipe owns the bus, and `cbus_valid` is 0 with no request.
- R3: A completion stage's moving-or-empty flag is clear exactly when it requests the bus and is not granted. Bit LONG_DEPTH-1 of `moe_long` and bit 1 of `moe_short` are the completion stages.
- R4: An intermediate long stage (bits 1 to LONG_DEPTH-2 of `moe_long`) clears its moving-or-empty flag exactly when it holds an entry and its successor's flag is clear.
- R5: An operand hazard exists when an issue slot is valid and its source or destination register has its scoreboard bit set. A register that equals `cbus_addr` while `cbus_valid` is 1 is exempt.
- R6: While `wait_state` is 1 the issue stage stalls even when it is empty, and inputs offered on the feed are not taken.
- R7: The two issue stages move in lock step. Bit 0 of `moe_long` equals bit 0 of `moe_short` equals `feed_ready`. A stall cause in either slot (blocked successor or operand hazard) stalls both slots.
- R8: No stall without a cause. An empty stage always has its moving-or-empty flag set, and a stage whose successor can move is never held.
- R9: A valid long slot leaving the issue stage sets the scoreboard bit of its destination. A long completion-bus grant clears the bit of `cbus_addr`. When both act on the same register in one cycle, the set wins.
- R10: A stage loads from its predecessor only when its own moving-or-empty flag is set, and it becomes a bubble if the predecessor does not move into it. A stage with a clear flag keeps its entry and destination unchanged.
- R11: `rtm_long` and `rtm_short` report stage occupancy. Bit 0 is the issue slot and higher bits are later stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| feed_valid_l | input | 1 | Instruction offered for the long slot |
| feed_src_l | input | REG_AW | Source register of the long-slot instruction |
| feed_dst_l | input | REG_AW | Destination register of the long-slot instruction |
| feed_valid_s | input | 1 | Instruction offered for the short slot |
| feed_src_s | input | REG_AW | Source register of the short-slot instruction |
| feed_dst_s | input | REG_AW | Destination register of the short-slot instruction |
| wait_state | input | 1 | Machine wait state; blocks issue |
| feed_ready | output | 1 | Issue stage accepts the feed on this edge |
| cbus_valid | output | 1 | Completion bus carries a write |
| cbus_addr | output | REG_AW | Register written by the completion bus |
| cbus_long | output | 1 | Completion bus owned by the long pipe |
| moe_long | output | LONG_DEPTH | Long-pipe moving-or-empty flags, bit 0 = issue |
| moe_short | output | 2 | Short-pipe moving-or-empty flags, bit 0 = issue |
| rtm_long | output | LONG_DEPTH | Long-pipe require-to-move flags |
| rtm_short | output | 2 | Short-pipe require-to-move flags |
| scb_bits | output | NUM_REGS | Scoreboard contents |

## Verification
The hardest situation to reach from the ports is one where the short completion stage and the long completion stage request the bus in the same cycle while another long entry sits directly behind the losing one. Only that case shows the denied grant propagating back as a stall. The stimulus gets there by issuing two long instructions on consecutive cycles and then a short one two cycles after the first, so that all three arrive together. The bypass exemption and the same-cycle set-over-clear case are reached by issuing an instruction that reads and writes a register still owed by an earlier long instruction, and by holding it until that register appears on the bus.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_SHORT = 2'd1,
        BUS_LONG  = 2'd2
    } bus_owner_e;

    function automatic bus_owner_e pick_owner(input logic req_short, input logic req_long);
        if (req_short)     return BUS_SHORT;
        else if (req_long) return BUS_LONG;
        else               return BUS_IDLE;
    endfunction

endpackage

// File: rtl/ilk_cbus_arb.sv
module ilk_cbus_arb
    import ilk_pkg::*;
#(
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_short,
    input  logic [REG_AW-1:0] addr_short,
    input  logic              req_long,
    input  logic [REG_AW-1:0] addr_long,
    output logic              gnt_short,
    output logic              gnt_long,
    output logic              bus_vld,
    output logic [REG_AW-1:0] bus_addr
);

    bus_owner_e owner;

    always_comb begin
        owner     = pick_owner(req_short, req_long);
        gnt_short = (owner == BUS_SHORT);
        gnt_long  = (owner == BUS_LONG);
        bus_vld   = (owner != BUS_IDLE);
        bus_addr  = (owner == BUS_LONG) ? addr_long : addr_short;
    end

    // R2: the short pipe is never refused
    assert_short_priority_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_short |-> (gnt_short && !gnt_long));

    // R2: a lone long request is granted
    assert_long_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_long && !req_short) |-> gnt_long);

endmodule

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard #(
    parameter int NUM_REGS = 8,
    parameter int REG_AW   = 3,
    parameter int NUM_CHK  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           set_en,
    input  logic [REG_AW-1:0]              set_addr,
    input  logic                           clr_en,
    input  logic [REG_AW-1:0]              clr_addr,
    input  logic                           bus_vld,
    input  logic [REG_AW-1:0]              bus_addr,
    input  logic [NUM_CHK-1:0]             chk_vld,
    input  logic [NUM_CHK-1:0][REG_AW-1:0] chk_src,
    input  logic [NUM_CHK-1:0][REG_AW-1:0] chk_dst,
    output logic [NUM_CHK-1:0]             hazard,
    output logic [NUM_REGS-1:0]            bits
);

    logic [NUM_REGS-1:0] scb_d, scb_q;

    always_comb begin
        scb_d = scb_q;
        if (clr_en) scb_d[clr_addr] = 1'b0;
        if (set_en) scb_d[set_addr] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) scb_q <= '0;
        else        scb_q <= scb_d;
    end

    for (genvar q = 0; q < NUM_CHK; q++) begin : g_chk
        logic src_busy, dst_busy;
        always_comb begin
            src_busy  = scb_q[chk_src[q]] && !(bus_vld && (bus_addr == chk_src[q]));
            dst_busy  = scb_q[chk_dst[q]] && !(bus_vld && (bus_addr == chk_dst[q]));
            hazard[q] = chk_vld[q] && (src_busy || dst_busy);
        end
    end

    assign bits = scb_q;

    // R9: an issued destination is marked outstanding on the next cycle
    assert_sb_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> scb_q[$past(set_addr)]);

    // R9: a completed register is released unless reissued in the same cycle
    assert_sb_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && (set_addr == clr_addr))) |=> !scb_q[$past(clr_addr)]);

endmodule

// File: rtl/twin_pipe_interlock.sv
module twin_pipe_interlock #(
    parameter  int NUM_REGS   = 8,
    parameter  int LONG_DEPTH = 4,
    localparam int REG_AW     = $clog2(NUM_REGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  feed_valid_l,
    input  logic [REG_AW-1:0]     feed_src_l,
    input  logic [REG_AW-1:0]     feed_dst_l,
    input  logic                  feed_valid_s,
    input  logic [REG_AW-1:0]     feed_src_s,
    input  logic [REG_AW-1:0]     feed_dst_s,
    input  logic                  wait_state,
    output logic                  feed_ready,
    output logic                  cbus_valid,
    output logic [REG_AW-1:0]     cbus_addr,
    output logic                  cbus_long,
    output logic [LONG_DEPTH-1:0] moe_long,
    output logic [1:0]            moe_short,
    output logic [LONG_DEPTH-1:0] rtm_long,
    output logic [1:0]            rtm_short,
    output logic [NUM_REGS-1:0]   scb_bits
);

    localparam int LAST = LONG_DEPTH - 1;

    typedef struct packed {
        logic              vld;
        logic [REG_AW-1:0] dst;
    } slot_t;

    typedef struct packed {
        logic              vld;
        logic [REG_AW-1:0] src;
        logic [REG_AW-1:0] dst;
    } iss_t;

    typedef struct packed {
        iss_t                   il;
        iss_t                   is;
        slot_t [LAST:1]         lp;
        slot_t                  s2;
    } state_t;

    state_t st_d, st_q;

    logic              gnt_s, gnt_l, bus_vld;
    logic [REG_AW-1:0] bus_addr;
    logic [1:0]        hz;
    logic              stall_l, stall_s, issue_go;

    ilk_cbus_arb #(.REG_AW(REG_AW)) i_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_short  (st_q.s2.vld),
        .addr_short (st_q.s2.dst),
        .req_long   (st_q.lp[LAST].vld),
        .addr_long  (st_q.lp[LAST].dst),
        .gnt_short  (gnt_s),
        .gnt_long   (gnt_l),
        .bus_vld    (bus_vld),
        .bus_addr   (bus_addr)
    );

    ilk_scoreboard #(.NUM_REGS(NUM_REGS), .REG_AW(REG_AW), .NUM_CHK(2)) i_scb (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (st_q.il.vld && issue_go),
        .set_addr (st_q.il.dst),
        .clr_en   (gnt_l),
        .clr_addr (bus_addr),
        .bus_vld  (bus_vld),
        .bus_addr (bus_addr),
        .chk_vld  ({st_q.is.vld, st_q.il.vld}),
        .chk_src  ({st_q.is.src, st_q.il.src}),
        .chk_dst  ({st_q.is.dst, st_q.il.dst}),
        .hazard   (hz),
        .bits     (scb_bits)
    );

    // moving-or-empty flags, evaluated from the completion end backwards
    always_comb begin
        moe_long       = '0;
        moe_long[LAST] = !(st_q.lp[LAST].vld && !gnt_l);
        for (int i = LAST - 1; i >= 1; i--)
            moe_long[i] = !(st_q.lp[i].vld && !moe_long[i+1]);
        moe_short[1] = !(st_q.s2.vld && !gnt_s);
        // per-slot stall causes without the lock-step cross term
        stall_l = (st_q.il.vld && !moe_long[1]) || wait_state || hz[0];
        stall_s = (st_q.is.vld && !moe_short[1]) || hz[1];
        issue_go     = !(stall_l || stall_s);
        moe_long[0]  = issue_go;
        moe_short[0] = issue_go;
    end

    // next-state computation
    always_comb begin
        st_d = st_q;
        if (issue_go) begin
            st_d.il = '{vld: feed_valid_l, src: feed_src_l, dst: feed_dst_l};
            st_d.is = '{vld: feed_valid_s, src: feed_src_s, dst: feed_dst_s};
        end
        if (moe_long[1])
            st_d.lp[1] = '{vld: st_q.il.vld && issue_go, dst: st_q.il.dst};
        for (int i = 2; i <= LAST; i++) begin
            if (moe_long[i])
                st_d.lp[i] = '{vld: st_q.lp[i-1].vld && moe_long[i-1], dst: st_q.lp[i-1].dst};
        end
        if (moe_short[1])
            st_d.s2 = '{vld: st_q.is.vld && issue_go, dst: st_q.is.dst};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rtm_long = '0;
        rtm_long[0] = st_q.il.vld;
        for (int i = 1; i <= LAST; i++) rtm_long[i] = st_q.lp[i].vld;
        rtm_short = {st_q.s2.vld, st_q.is.vld};
    end

    assign feed_ready = issue_go;
    assign cbus_valid = bus_vld;
    assign cbus_addr  = bus_addr;
    assign cbus_long  = gnt_l;

    // R6: wait state always blocks issue
    assert_wait_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wait_state |-> !feed_ready);

    // R10: a held issue stage keeps both slots
    assert_issue_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !feed_ready |=> ($stable(st_q.il) && $stable(st_q.is)));

    for (genvar g = 1; g <= LAST; g++) begin : g_stage_chk
        // R10: a blocked occupied stage keeps its entry
        assert_stage_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.lp[g].vld && !moe_long[g]) |=> (st_q.lp[g].vld && $stable(st_q.lp[g].dst)));
        // R8: an empty stage never blocks its predecessor
        assert_empty_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !rtm_long[g] |-> moe_long[g]);
    end

endmodule

// File: tb/test_twin_pipe_interlock.sv
module test_twin_pipe_interlock;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       fvl, fvs, wt;
    logic [2:0] fsl, fdl, fss, fds;
    logic       feed_ready, cbus_valid, cbus_long;
    logic [2:0] cbus_addr;
    logic [3:0] moe_long, rtm_long;
    logic [1:0] moe_short, rtm_short;
    logic [7:0] scb_bits;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    twin_pipe_interlock i_twin_pipe_interlock (
        .clk(clk), .rst_n(rst_n),
        .feed_valid_l(fvl), .feed_src_l(fsl), .feed_dst_l(fdl),
        .feed_valid_s(fvs), .feed_src_s(fss), .feed_dst_s(fds),
        .wait_state(wt), .feed_ready(feed_ready),
        .cbus_valid(cbus_valid), .cbus_addr(cbus_addr), .cbus_long(cbus_long),
        .moe_long(moe_long), .moe_short(moe_short),
        .rtm_long(rtm_long), .rtm_short(rtm_short), .scb_bits(scb_bits)
    );

    typedef struct packed {
        logic       vl; logic [2:0] sl; logic [2:0] dl;
        logic       vs; logic [2:0] ss; logic [2:0] ds;
        logic       w;
        logic       rdy; logic cv; logic [2:0] ca; logic cl;
        logic [7:0] scb;
    } vec_t;

    // hazard, bypass and set-over-clear sequence
    localparam vec_t TBL [6] = '{
        '{1'b1,3'd1,3'd2, 1'b1,3'd3,3'd4, 1'b0, 1'b1,1'b0,3'd0,1'b0, 8'h00},
        '{1'b1,3'd2,3'd2, 1'b0,3'd0,3'd0, 1'b0, 1'b1,1'b0,3'd0,1'b0, 8'h00},
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0, 1'b0,1'b1,3'd4,1'b0, 8'h04},
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0, 1'b0,1'b0,3'd0,1'b0, 8'h04},
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0, 1'b1,1'b1,3'd2,1'b1, 8'h04},
        '{1'b0,3'd0,3'd0, 1'b0,3'd0,3'd0, 1'b0, 1'b1,1'b0,3'd0,1'b0, 8'h04}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic vl, input logic [2:0] sl, input logic [2:0] dl,
                         input logic vs, input logic [2:0] ss, input logic [2:0] ds,
                         input logic w);
        fvl = vl; fsl = sl; fdl = dl; fvs = vs; fss = ss; fds = ds; wt = w;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // each step: drive after a falling edge, sample 1 ns later, rising edge follows
    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0);
        do_reset();
        #1;
        check("R1 ready", feed_ready, 1);
        check("R1 moe_long", moe_long, 4'hF);
        check("R1 moe_short", moe_short, 2'h3);
        check("R1 scb", scb_bits, 0);
        check("R11 rtm empty", {rtm_long, rtm_short}, 0);
        check("R2 bus idle", cbus_valid, 0);

        // table walk (starts at the same falling edge as the reset checks)
        for (int k = 0; k < 6; k++) begin
            if (k != 0) step();
            drive(TBL[k].vl, TBL[k].sl, TBL[k].dl, TBL[k].vs, TBL[k].ss, TBL[k].ds, TBL[k].w);
            #1;
            check($sformatf("R5/R7 ready step%0d", k), feed_ready, TBL[k].rdy);
            check($sformatf("R2 cbus_valid step%0d", k), cbus_valid, TBL[k].cv);
            if (TBL[k].cv) begin
                check($sformatf("R2 cbus_addr step%0d", k), cbus_addr, TBL[k].ca);
                check($sformatf("R2 cbus_long step%0d", k), cbus_long, TBL[k].cl);
            end
            check($sformatf("R9 scb step%0d", k), scb_bits, TBL[k].scb);
        end

        // wait state: stalls an empty issue stage, feed is not taken
        do_reset();
        drive(1, 0, 5, 1, 0, 6, 1);
        #1;
        check("R6 wait ready", feed_ready, 0);
        check("R7 wait short lockstep", moe_short[0], 0);
        step();
        drive(0, 0, 0, 0, 0, 0, 0);
        #1;
        check("R6 wait feed ignored scb", scb_bits, 0);
        check("R10 wait issue stays empty", rtm_long[0], 0);
        check("R6 released ready", feed_ready, 1);

        // bus collision with back-pressure
        do_reset();
        drive(1, 0, 1, 0, 0, 0, 0);
        step(); drive(1, 0, 3, 0, 0, 0, 0);
        step(); drive(0, 0, 0, 1, 0, 5, 0);
        step(); drive(0, 0, 0, 0, 0, 0, 0);
        #1;
        check("R8 ready before collision", feed_ready, 1);
        step(); #1;
        check("R2 short wins addr", cbus_addr, 5);
        check("R2 short wins owner", cbus_long, 0);
        check("R3 long completion blocked", moe_long[3], 0);
        check("R4 backpressure stage3", moe_long[2], 0);
        check("R8 empty stage2 moves", moe_long[1], 1);
        check("R3 short completion moves", moe_short[1], 1);
        check("R11 rtm_long", rtm_long, 4'b1100);
        check("R11 rtm_short", rtm_short, 2'b10);
        check("R9 two outstanding", scb_bits, 8'h0A);
        step(); #1;
        check("R2 long granted", {cbus_valid, cbus_long, cbus_addr}, {1'b1, 1'b1, 3'd1});
        check("R3 granted completion moves", moe_long[3], 1);
        check("R10 held entry kept", rtm_long, 4'b1100);
        step(); #1;
        check("R2 second long completion", cbus_addr, 3);
        check("R9 cleared on completion", scb_bits, 8'h08);

        // destination hazard in the short slot stalls both slots
        do_reset();
        drive(1, 0, 7, 0, 0, 0, 0);
        step(); drive(0, 0, 0, 1, 1, 7, 0);
        #1;
        check("R7 first issue ready", feed_ready, 1);
        step(); drive(0, 0, 0, 0, 0, 0, 0);
        #1;
        check("R5 short dst hazard", feed_ready, 0);
        check("R7 long slot follows short", moe_long[0], 0);
        check("R8 stage2 not held", moe_long[1], 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule